// File: doc/BRIEF.md
# Indirect Performance Counter Bank

This block is a compact performance-monitor register bank. It holds a parameterised set of programmable event counters plus one dedicated cycle counter. Software never addresses a counter directly. It first writes a counter index into a select register. Every later access through the event-type window or the count window then lands on the counter that index names. A spare index value reaches the cycle counter. For that counter, the type window holds a small filter register in place of an event number.

Each event counter compares its programmed event number against a bank of event inputs. It adds one in any cycle where the chosen input is high. The cycle counter adds one on every cycle where the cycle tick is high, unless its filter pauses it.

The register port is a plain address / write-enable / write-data / read-data interface. It has no valid/ready handshake, because every access completes in one cycle. Writes take effect at the clock edge where the write enable is sampled. Read data is a combinational function of the address and the current state, so there is no back-pressure to manage.

Top module: `pmu_indirect_bank`

## Requirements
- R1: After reset the select register reads 0. Reading address 0 returns the 5-bit select field in bits [4:0] and zero in bits [31:5]. A write to address 0 loads only wdata[4:0]; the upper bits are discarded.
- R2: With select value n below NUM_CNT, address 1 reads and writes the event-type register of counter n (EVT_W bits, zero-extended). Address 2 reads and writes the count of counter n.
- R3: With select value 31, address 2 reads and writes the cycle counter. Address 1 reads and writes the cycle filter register (FLT_W bits).
- R4: With a select value from NUM_CNT to 30, addresses 1 and 2 read zero. Writes through them change no counter, type or filter register.
- R5: An event counter adds exactly one in a cycle where evt_in[type] is high and its type value is below NUM_EVT. A type value of NUM_EVT or more never counts.
- R6: The cycle counter adds one on each cycle where cyc_tick is high and filter bit 0 is clear. When filter bit 0 is set, the cycle counter holds.
- R7: A write through address 2 sets the selected counter to the written value. This holds even when an increment is due in the same cycle.
- R8: Reset clears every count, every event-type register and the cycle filter.
- R9: Address 3 reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address: 0 select, 1 type window, 2 count window, 3 spare |
| reg_wr | input | 1 | Write enable, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | NUM_EVT | Event inputs, one bit per event number |
| cyc_tick | input | 1 | Cycle-count enable |

## Verification
The assertions watch several behaviours on every cycle:
- the zero upper bits of the select readback;
- the zero readback for unimplemented selects and the spare address;
- the load of the select field;
- the step-or-hold behaviour of the cycle counter under the tick and the filter;
- the win of a count write over a same-cycle tick.

Only the bench's scenarios show the rest:
- each event counter following its own programmed event number across a stream of event patterns;
- out-of-range event numbers never counting;
- writes to unimplemented selects leaving the real counters untouched;
- every one of the 32 select values reading back intact.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 5;
  localparam logic [SEL_W-1:0] CYC_IDX = 5'd31;

  typedef enum logic [1:0] {
    RA_SEL   = 2'd0,
    RA_TYPE  = 2'd1,
    RA_COUNT = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pmu_sel_reg.sv
module pmu_sel_reg
  import pmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] din,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sel <= '0;
    else if (load) sel <= din;
  end
endmodule

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr #(
  parameter int NUM_EVT = 8,
  parameter int EVT_W   = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_type,
  input  logic               wr_cnt,
  input  logic [31:0]        wdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [EVT_W-1:0]   type_q,
  output logic [CNT_W-1:0]   cnt_q
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic in_range;
  logic hit;

  assign in_range = (type_q < EVT_W'(NUM_EVT));
  assign hit      = in_range && evt_in[type_q[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)       type_q <= '0;
    else if (wr_type) type_q <= wdata[EVT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata[CNT_W-1:0];
    else if (hit)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
  parameter int CNT_W = 32,
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_flt,
  input  logic             wr_cnt,
  input  logic [31:0]      wdata,
  input  logic             tick,
  output logic [FLT_W-1:0] flt_q,
  output logic [CNT_W-1:0] cnt_q
);
  logic run;
  assign run = tick && !flt_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      flt_q <= '0;
    else if (wr_flt) flt_q <= wdata[FLT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata[CNT_W-1:0];
    else if (run)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pmu_indirect_bank.sv
module pmu_indirect_bank
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 8,
  parameter int EVT_W   = 8,
  parameter int CNT_W   = 32,
  parameter int FLT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               cyc_tick
);
  logic [SEL_W-1:0] sel_q;
  logic             wr_sel, wr_type, wr_cnt;
  logic             sel_cyc;

  logic [EVT_W-1:0] type_arr [NUM_CNT];
  logic [CNT_W-1:0] cnt_arr  [NUM_CNT];
  logic [FLT_W-1:0] cyc_flt_q;
  logic [CNT_W-1:0] cyc_cnt_q;

  logic [DATA_W-1:0] type_rd, cnt_rd;

  assign wr_sel  = reg_wr && (reg_addr == RA_SEL);
  assign wr_type = reg_wr && (reg_addr == RA_TYPE);
  assign wr_cnt  = reg_wr && (reg_addr == RA_COUNT);
  assign sel_cyc = (sel_q == CYC_IDX);

  pmu_sel_reg u_sel (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_sel),
    .din  (reg_wdata[SEL_W-1:0]),
    .sel  (sel_q)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_evt
    logic pick;
    assign pick = (sel_q == SEL_W'(n));
    pmu_evt_ctr #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_type(wr_type && pick),
      .wr_cnt (wr_cnt && pick),
      .wdata  (reg_wdata),
      .evt_in (evt_in),
      .type_q (type_arr[n]),
      .cnt_q  (cnt_arr[n])
    );
  end

  pmu_cyc_ctr #(.CNT_W(CNT_W), .FLT_W(FLT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_flt(wr_type && sel_cyc),
    .wr_cnt(wr_cnt && sel_cyc),
    .wdata (reg_wdata),
    .tick  (cyc_tick),
    .flt_q (cyc_flt_q),
    .cnt_q (cyc_cnt_q)
  );

  always_comb begin
    type_rd = '0;
    cnt_rd  = '0;
    if (sel_cyc) begin
      type_rd = DATA_W'(cyc_flt_q);
      cnt_rd  = DATA_W'(cyc_cnt_q);
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (sel_q == SEL_W'(i)) begin
          type_rd = DATA_W'(type_arr[i]);
          cnt_rd  = DATA_W'(cnt_arr[i]);
        end
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_SEL:   reg_rdata = DATA_W'(sel_q);
      RA_TYPE:  reg_rdata = type_rd;
      RA_COUNT: reg_rdata = cnt_rd;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int FLT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             cyc_tick,
  input logic [4:0]       sel_q,
  input logic [FLT_W-1:0] cyc_flt_q,
  input logic [CNT_W-1:0] cyc_cnt_q
);
  logic cyc_wr;
  assign cyc_wr = reg_wr && (reg_addr == 2'd2) && (sel_q == 5'd31);

  AST_SEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[31:5] == '0)); // R1

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (sel_q == $past(reg_wdata[4:0]))); // R1

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == 2'd1 || reg_addr == 2'd2) && (int'(sel_q) >= NUM_CNT) && (sel_q != 5'd31))
      |-> (reg_rdata == '0)); // R4

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_wr && cyc_tick && !cyc_flt_q[0]) |=> (cyc_cnt_q == $past(cyc_cnt_q) + CNT_W'(1))); // R6

  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_wr && (!cyc_tick || cyc_flt_q[0])) |=> $stable(cyc_cnt_q)); // R6

  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> (cyc_cnt_q == $past(reg_wdata[CNT_W-1:0]))); // R7

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0)); // R9
endmodule

bind pmu_indirect_bank pmu_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .FLT_W(FLT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .cyc_tick (cyc_tick),
  .sel_q    (sel_q),
  .cyc_flt_q(cyc_flt_q),
  .cyc_cnt_q(cyc_cnt_q)
);

// File: tb/sim_pmu_indirect_bank.sv
module sim_pmu_indirect_bank;
  localparam int N  = 4;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NE-1:0] evt_in = '0;
  logic        cyc_tick = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmu_indirect_bank #(.NUM_CNT(N), .NUM_EVT(NE), .EVT_W(8), .CNT_W(32), .FLT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .cyc_tick(cyc_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  logic [31:0] rd;
  logic [31:0] exp_cnt [N];
  logic [7:0]  exp_typ [N];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    bus_rd(2'd0, rd); chk("R8 sel", rd, 32'd0);
    bus_rd(2'd1, rd); chk("R8 type0", rd, 32'd0);
    bus_rd(2'd2, rd); chk("R8 cnt0", rd, 32'd0);
    bus_wr(2'd0, 32'd31);
    bus_rd(2'd1, rd); chk("R8 filter", rd, 32'd0);
    bus_rd(2'd2, rd); chk("R8 cyc", rd, 32'd0);

    // R1: every select value, upper bits set in the write
    for (int i = 0; i < 32; i++) begin
      bus_wr(2'd0, {27'h5AAAAAA, 5'(i)});
      bus_rd(2'd0, rd); chk("R1 sel readback", rd, 32'(i));
    end

    // R2: program each implemented counter
    for (int n = 0; n < N; n++) begin
      exp_typ[n] = (n == 0) ? 8'd0 : (n == 1) ? 8'd3 : (n == 2) ? 8'd7 : 8'd9;
      exp_cnt[n] = 32'd100 * 32'(n) + 32'd7;
      bus_wr(2'd0, 32'(n));
      bus_wr(2'd1, {24'hFFFFFF, exp_typ[n]});
      bus_wr(2'd2, exp_cnt[n]);
      bus_rd(2'd1, rd); chk("R2 type", rd, 32'(exp_typ[n]));
      bus_rd(2'd2, rd); chk("R2 count", rd, exp_cnt[n]);
    end

    // R4: unimplemented selects
    for (int s = N; s < 31; s++) begin
      bus_wr(2'd0, 32'(s));
      bus_wr(2'd1, 32'hAA);
      bus_wr(2'd2, 32'd12345);
      bus_rd(2'd1, rd); chk("R4 type zero", rd, 32'd0);
      bus_rd(2'd2, rd); chk("R4 count zero", rd, 32'd0);
    end
    for (int n = 0; n < N; n++) begin
      bus_wr(2'd0, 32'(n));
      bus_rd(2'd1, rd); chk("R4 type kept", rd, 32'(exp_typ[n]));
      bus_rd(2'd2, rd); chk("R4 count kept", rd, exp_cnt[n]);
    end
    bus_wr(2'd0, 32'd31);
    bus_rd(2'd1, rd); chk("R4 filter kept", rd, 32'd0);
    bus_rd(2'd2, rd); chk("R4 cyc kept", rd, 32'd0);

    // R9: spare address
    bus_wr(2'd3, 32'hFFFF_FFFF);
    bus_rd(2'd3, rd); chk("R9 spare zero", rd, 32'd0);
    bus_rd(2'd0, rd); chk("R9 sel kept", rd, 32'd31);

    // R5: event stream
    for (int i = 0; i < 64; i++) begin
      logic [NE-1:0] pat;
      @(negedge clk);
      pat = NE'((i * 29 + 5) ^ (i >> 1));
      evt_in = pat;
      for (int n = 0; n < N; n++)
        if (exp_typ[n] < 8'(NE) && pat[exp_typ[n][2:0]]) exp_cnt[n] = exp_cnt[n] + 32'd1;
    end
    @(negedge clk);
    evt_in = '0;
    for (int n = 0; n < N; n++) begin
      bus_wr(2'd0, 32'(n));
      bus_rd(2'd2, rd); chk("R5 event count", rd, exp_cnt[n]);
    end

    // R3/R6: cycle counter
    bus_wr(2'd0, 32'd31);
    bus_wr(2'd2, 32'd1000);
    bus_rd(2'd2, rd); chk("R3 cyc write", rd, 32'd1000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); cyc_tick = (i % 3 != 1);
    end
    @(negedge clk); cyc_tick = 1'b0;
    bus_rd(2'd2, rd); chk("R6 cyc ticks", rd, 32'd1013);
    bus_wr(2'd1, 32'hFFFF_FFF1);
    bus_rd(2'd1, rd); chk("R3 filter", rd, 32'd1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); cyc_tick = 1'b1;
    end
    @(negedge clk); cyc_tick = 1'b0;
    bus_rd(2'd2, rd); chk("R6 paused", rd, 32'd1013);
    bus_wr(2'd1, 32'd0);

    // R7: write beats same-cycle increment
    @(negedge clk);
    cyc_tick = 1'b1; reg_addr = 2'd2; reg_wr = 1'b1; reg_wdata = 32'd77;
    @(negedge clk);
    cyc_tick = 1'b0; reg_wr = 1'b0;
    bus_rd(2'd2, rd); chk("R7 cyc write wins", rd, 32'd77);

    bus_wr(2'd0, 32'd1);
    @(negedge clk);
    evt_in = '1; reg_addr = 2'd2; reg_wr = 1'b1; reg_wdata = 32'd500;
    @(negedge clk);
    evt_in = '0; reg_wr = 1'b0;
    bus_rd(2'd2, rd); chk("R7 event write wins", rd, 32'd500);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule